// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block turns a request from the processor core into the T-state sequence of one machine cycle on a multiplexed address/data bus. The core presents a cycle kind together with an address and write data. The sequencer then steps through T1, T2, any number of wait states (TW), T3 and, for opcode fetches only, T4. In each state it drives the address-latch strobe, the read, write and interrupt-acknowledge strobes, the I/O-versus-memory select and the refresh strobe. It also decides what the shared low byte carries and what the upper address byte shows. At the edge where a read or acknowledge strobe ends, it captures the byte on the bus, and it raises a one-cycle end-of-cycle pulse in the last T-state.

An opcode fetch is followed at once by a dynamic-memory refresh slot. The address-latch strobe fires a second time in T3 to publish the refresh address, and the upper byte shows the interrupt vector register. A slow device can hold the cycle open by pulling the active-low wait input. Wait is also honoured in the strobe-less cycle that follows an interrupt being accepted. The block also emits a free-running output clock at half the input clock rate.

Top module: `bus_cycle_seq`

## Requirements
- R1: While `rst` is high and in idle, `ale`=0, `rd_n`=`wr_n`=`inta_n`=`rfsh_n`=1, `io_m`=0, `ad_oe`=0, `ad_out`=0, `a_hi`=0, `done`=0 and `rdata`=0.
- R2: A request (`req`=1) is accepted only in idle or in the cycle where `done` is high, and only for `req_kind` codes 0 to 6. Code 7 is ignored. An accepted request starts T1 on the next clock. The state order is T1, T2, zero or more TW, T3, and T4 only for a fetch. `done` is high only in the last T-state.
- R3: `ale` is high in T1 of every cycle and in T3 of a fetch (kind 0), and low in all other states.
- R4: In T3 and T4 of a fetch, `rfsh_n` is 0, `ad_out` carries `rfsh_addr` with `ad_oe`=1, and `a_hi` carries `ivec`. `rfsh_n` is 1 at all other times.
- R5: In T1, `ad_oe`=1 and `ad_out` is the low byte of the address. From T1 to the end of the cycle, `a_hi` is the high address byte for memory-space kinds (0, 1, 2, 5, 6), and a copy of the low byte (the port number) for I/O kinds 3 and 4. `ad_out` is 0 whenever `ad_oe` is 0.
- R6: `io_m` is 1 from T1 to the end of the cycle for kinds 3, 4, 5 and 6, and 0 for kinds 0, 1 and 2.
- R7: `rd_n` is low in T2 and every TW of kinds 0, 1 and 3. `inta_n` is low in T2 and TW of kind 5. Kind 6 (post-acceptance cycle) asserts no strobe.
- R8: `wait_n` is sampled at the end of T2 and of each TW for every kind, and each low sample adds one TW. It has no effect in T1, T3, T4 or idle. A cycle lasts 3 + waits clocks, plus one for a fetch.
- R9: `rdata` loads `ad_in` at the clock edge that ends the last T2/TW of kinds 0, 1, 3 and 5 (where `rd_n`/`inta_n` rise), and holds at all other times.
- R10: For write kinds 2 and 4, `ad_out` carries the write data with `ad_oe`=1 from T2 through T3. `wr_n` is low only in T3, after the final high sample of `wait_n`.
- R11: `clk_out` is 0 during reset and toggles on every clock afterwards.
- R12: Kind, address and write data are captured when a request is accepted. Changing them during the cycle has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; one T-state per cycle |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start-cycle request from the core |
| req_kind | input | 3 | Cycle kind code 0..6 |
| req_addr | input | ADDR_W | Cycle address |
| req_wdata | input | DATA_W | Write data |
| wait_n | input | 1 | Active-low wait from slow devices |
| ad_in | input | DATA_W | Byte read from the shared bus |
| rfsh_addr | input | DATA_W | Refresh address from the refresh counter |
| ivec | input | ADDR_W-DATA_W | Interrupt vector register contents |
| clk_out | output | 1 | Half-rate clock output |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Interrupt-acknowledge strobe, active low |
| io_m | output | 1 | 1 = I/O space, 0 = memory |
| rfsh_n | output | 1 | Refresh strobe, active low |
| ad_out | output | DATA_W | Byte driven on the shared bus |
| ad_oe | output | 1 | Shared-bus output enable |
| a_hi | output | ADDR_W-DATA_W | Upper address byte |
| rdata | output | DATA_W | Captured read/acknowledge byte |
| done | output | 1 | End-of-cycle pulse |

## Verification
The bench targets a fetch with waits followed back-to-back by another cycle. A design that counted the refresh slot wrongly would end the fetch a clock early or drop the second address strobe. It holds wait low during T1, T3 and T4 to catch a sequencer that stretches the wrong state. It runs the strobe-less post-acceptance cycle with waits, which exposes a design that leaks a read strobe or ignores wait there. It also scrambles the request inputs mid-cycle and issues the unused kind code, so a design that failed to latch its context, or that accepted illegal codes, would show it on the bus.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic [2:0] {
        KIND_FETCH    = 3'd0,
        KIND_MEM_RD   = 3'd1,
        KIND_MEM_WR   = 3'd2,
        KIND_IO_RD    = 3'd3,
        KIND_IO_WR    = 3'd4,
        KIND_IRQ_ACK  = 3'd5,
        KIND_POST_ACK = 3'd6
    } bus_kind_e;

    localparam logic [2:0] KIND_LAST = 3'd6;

    typedef enum logic [2:0] {
        TS_IDLE = 3'd0,
        TS_T1   = 3'd1,
        TS_T2   = 3'd2,
        TS_TW   = 3'd3,
        TS_T3   = 3'd4,
        TS_T4   = 3'd5
    } tstate_e;

    typedef struct packed {
        logic ale;
        logic rd_n;
        logic wr_n;
        logic inta_n;
        logic rfsh_n;
        logic io_m;
    } strobe_t;

    localparam strobe_t STROBE_QUIET = '{ale: 1'b0, rd_n: 1'b1, wr_n: 1'b1,
                                         inta_n: 1'b1, rfsh_n: 1'b1, io_m: 1'b0};

    function automatic logic kind_legal(input logic [2:0] raw);
        return raw <= KIND_LAST;
    endfunction

    function automatic logic is_fetch(input bus_kind_e k);
        return k == KIND_FETCH;
    endfunction

    function automatic logic reads_bus(input bus_kind_e k);
        return (k == KIND_FETCH) || (k == KIND_MEM_RD) || (k == KIND_IO_RD);
    endfunction

    function automatic logic writes_bus(input bus_kind_e k);
        return (k == KIND_MEM_WR) || (k == KIND_IO_WR);
    endfunction

    function automatic logic uses_ack(input bus_kind_e k);
        return k == KIND_IRQ_ACK;
    endfunction

    function automatic logic io_space(input bus_kind_e k);
        return (k == KIND_IO_RD) || (k == KIND_IO_WR) ||
               (k == KIND_IRQ_ACK) || (k == KIND_POST_ACK);
    endfunction

    function automatic logic port_cycle(input bus_kind_e k);
        return (k == KIND_IO_RD) || (k == KIND_IO_WR);
    endfunction

    function automatic logic strobe_phase(input tstate_e s);
        return (s == TS_T2) || (s == TS_TW);
    endfunction

    function automatic logic final_state(input tstate_e s, input bus_kind_e k);
        return ((s == TS_T3) && !is_fetch(k)) || (s == TS_T4);
    endfunction

endpackage

// File: rtl/bseq_clkdiv.sv
module bseq_clkdiv (
    input  logic clk,
    input  logic rst,
    output logic clk_out
);
    logic div_q;

    always_ff @(posedge clk) begin
        if (rst) div_q <= 1'b0;
        else     div_q <= ~div_q;
    end

    assign clk_out = div_q;
endmodule

// File: rtl/bseq_tstate.sv
module bseq_tstate
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              wait_n,
    output tstate_e           state,
    output bus_kind_e         ctx_kind,
    output logic [ADDR_W-1:0] ctx_addr,
    output logic [DATA_W-1:0] ctx_wdata,
    output logic              done,
    output logic              strobe_end
);
    tstate_e state_q, state_d;
    logic    take;

    assign done       = final_state(state_q, ctx_kind);
    assign take       = req && kind_legal(req_kind) && ((state_q == TS_IDLE) || done);
    assign strobe_end = strobe_phase(state_q) && wait_n;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_IDLE: state_d = TS_IDLE;
            TS_T1:   state_d = TS_T2;
            TS_T2,
            TS_TW:   state_d = wait_n ? TS_T3 : TS_TW;
            TS_T3:   state_d = is_fetch(ctx_kind) ? TS_T4 : TS_IDLE;
            TS_T4:   state_d = TS_IDLE;
            default: state_d = TS_IDLE;
        endcase
        if (take) state_d = TS_T1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= TS_IDLE;
            ctx_kind  <= KIND_MEM_RD;
            ctx_addr  <= '0;
            ctx_wdata <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                ctx_kind  <= bus_kind_e'(req_kind);
                ctx_addr  <= req_addr;
                ctx_wdata <= req_wdata;
            end
        end
    end

    assign state = state_q;

    AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (rst)
        (strobe_phase(state_q) && !wait_n) |=> (state_q == TS_TW)); // R8

    AST_CTX_HELD: assert property (@(posedge clk) disable iff (rst)
        ((state_q != TS_IDLE) && (state_q != TS_T1)) |-> ($stable(ctx_addr) && $stable(ctx_wdata))); // R12

    AST_T1_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (req && !kind_legal(req_kind) && (state_q == TS_IDLE)) |=> (state_q == TS_IDLE)); // R2
endmodule

// File: rtl/bseq_drive.sv
module bseq_drive
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  tstate_e                  state,
    input  bus_kind_e                ctx_kind,
    input  logic [ADDR_W-1:0]        ctx_addr,
    input  logic [DATA_W-1:0]        ctx_wdata,
    input  logic [DATA_W-1:0]        rfsh_addr,
    input  logic [ADDR_W-DATA_W-1:0] ivec,
    output strobe_t                  strb,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] a_hi
);
    localparam int HI_W = ADDR_W - DATA_W;

    logic [HI_W-1:0] port_hi;
    logic            active;
    logic            refresh_slot;

    generate
        if (HI_W == DATA_W) begin : g_port_same
            assign port_hi = ctx_addr[DATA_W-1:0];
        end else if (HI_W > DATA_W) begin : g_port_pad
            assign port_hi = {{(HI_W-DATA_W){1'b0}}, ctx_addr[DATA_W-1:0]};
        end else begin : g_port_cut
            assign port_hi = ctx_addr[HI_W-1:0];
        end
    endgenerate

    assign active       = (state != TS_IDLE);
    assign refresh_slot = is_fetch(ctx_kind) && ((state == TS_T3) || (state == TS_T4));

    always_comb begin
        strb        = STROBE_QUIET;
        strb.io_m   = active && io_space(ctx_kind);
        strb.rfsh_n = !refresh_slot;
        strb.ale    = (state == TS_T1) || (is_fetch(ctx_kind) && (state == TS_T3));
        if (strobe_phase(state)) begin
            strb.rd_n   = !reads_bus(ctx_kind);
            strb.inta_n = !uses_ack(ctx_kind);
        end
        if (state == TS_T3) strb.wr_n = !writes_bus(ctx_kind);
    end

    always_comb begin
        ad_oe  = 1'b0;
        ad_out = '0;
        if (state == TS_T1) begin
            ad_oe  = 1'b1;
            ad_out = ctx_addr[DATA_W-1:0];
        end else if (refresh_slot) begin
            ad_oe  = 1'b1;
            ad_out = rfsh_addr;
        end else if (writes_bus(ctx_kind) && (strobe_phase(state) || (state == TS_T3))) begin
            ad_oe  = 1'b1;
            ad_out = ctx_wdata;
        end
    end

    always_comb begin
        if (!active)                  a_hi = '0;
        else if (refresh_slot)        a_hi = ivec;
        else if (port_cycle(ctx_kind)) a_hi = port_hi;
        else                          a_hi = ctx_addr[ADDR_W-1:DATA_W];
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({!strb.rd_n, !strb.wr_n, !strb.inta_n})); // R7

    AST_IOM_STEADY: assert property (@(posedge clk) disable iff (rst)
        ((state != TS_IDLE) && (state != TS_T1)) |-> $stable(strb.io_m)); // R6
endmodule

// File: rtl/bseq_capture.sv
module bseq_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_end,
    input  logic              rd_n,
    input  logic              inta_n,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] rdata
);
    logic grab;

    assign grab = strobe_end && (!rd_n || !inta_n);

    always_ff @(posedge clk) begin
        if (rst)       rdata <= '0;
        else if (grab) rdata <= ad_in;
    end
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req,
    input  logic [2:0]               req_kind,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic                     wait_n,
    input  logic [DATA_W-1:0]        ad_in,
    input  logic [DATA_W-1:0]        rfsh_addr,
    input  logic [ADDR_W-DATA_W-1:0] ivec,
    output logic                     clk_out,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     inta_n,
    output logic                     io_m,
    output logic                     rfsh_n,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic [DATA_W-1:0]        rdata,
    output logic                     done
);
    tstate_e           state;
    bus_kind_e         ctx_kind;
    logic [ADDR_W-1:0] ctx_addr;
    logic [DATA_W-1:0] ctx_wdata;
    logic              strobe_end;
    strobe_t           strb;

    bseq_clkdiv u_clkdiv (
        .clk     (clk),
        .rst     (rst),
        .clk_out (clk_out)
    );

    bseq_tstate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tstate (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .req_kind   (req_kind),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .wait_n     (wait_n),
        .state      (state),
        .ctx_kind   (ctx_kind),
        .ctx_addr   (ctx_addr),
        .ctx_wdata  (ctx_wdata),
        .done       (done),
        .strobe_end (strobe_end)
    );

    bseq_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .ctx_kind  (ctx_kind),
        .ctx_addr  (ctx_addr),
        .ctx_wdata (ctx_wdata),
        .rfsh_addr (rfsh_addr),
        .ivec      (ivec),
        .strb      (strb),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .a_hi      (a_hi)
    );

    assign ale    = strb.ale;
    assign rd_n   = strb.rd_n;
    assign wr_n   = strb.wr_n;
    assign inta_n = strb.inta_n;
    assign io_m   = strb.io_m;
    assign rfsh_n = strb.rfsh_n;

    bseq_capture #(.DATA_W(DATA_W)) u_capture (
        .clk        (clk),
        .rst        (rst),
        .strobe_end (strobe_end),
        .rd_n       (strb.rd_n),
        .inta_n     (strb.inta_n),
        .ad_in      (ad_in),
        .rdata      (rdata)
    );

    AST_RDATA_ON_STROBE_END: assert property (@(posedge clk) disable iff (rst)
        !$stable(rdata) |-> ($rose(rd_n) || $rose(inta_n))); // R9

    AST_WR_AFTER_WAIT: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_n) |-> $past(wait_n)); // R10

    AST_NO_ALE_IN_T4: assert property (@(posedge clk) disable iff (rst)
        (!rfsh_n && !$past(rfsh_n)) |-> !ale); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R2

    AST_CLK_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (clk_out != $past(clk_out))); // R11
endmodule

// File: tb/bus_cycle_seq_bench.sv
`timescale 1ns/1ps
module bus_cycle_seq_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        req;
    logic [2:0]  req_kind;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata;
    logic        wait_n;
    logic [7:0]  ad_in;
    logic [7:0]  rfsh_addr;
    logic [7:0]  ivec;
    logic        clk_out, ale, rd_n, wr_n, inta_n, io_m, rfsh_n, ad_oe, done;
    logic [7:0]  ad_out, a_hi, rdata;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // reference model state
    int          ph = 0;      // 0 idle 1 T1 2 T2 3 TW 4 T3 5 T4
    logic [2:0]  mk = 3'd1;
    logic [15:0] ma = '0;
    logic [7:0]  mw = '0;
    int          mwaits = 0;
    int          mwcnt = 0;
    bit          mnoise = 1'b0;
    logic [7:0]  mrdata = '0;
    logic        mclk = 1'b0;
    int          req_waits = 0;
    bit          req_noise = 1'b0;
    logic [7:0]  lfsr = 8'h5a;
    int          obs_len = 0;

    always #2.5 clk = ~clk;

    bus_cycle_seq u_bus_cycle_seq (
        .clk(clk), .rst(rst), .req(req), .req_kind(req_kind), .req_addr(req_addr),
        .req_wdata(req_wdata), .wait_n(wait_n), .ad_in(ad_in), .rfsh_addr(rfsh_addr),
        .ivec(ivec), .clk_out(clk_out), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .inta_n(inta_n), .io_m(io_m), .rfsh_n(rfsh_n), .ad_out(ad_out), .ad_oe(ad_oe),
        .a_hi(a_hi), .rdata(rdata), .done(done)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit k_read(input logic [2:0] k);
        return k == 3'd0 || k == 3'd1 || k == 3'd3;
    endfunction
    function automatic bit k_write(input logic [2:0] k);
        return k == 3'd2 || k == 3'd4;
    endfunction
    function automatic bit m_done();
        return (ph == 4 && mk != 3'd0) || ph == 5;
    endfunction

    // model update
    always @(posedge clk) begin
        int nx;
        if (rst) begin
            ph = 0; mrdata = '0; mclk = 1'b0; mwcnt = 0;
        end else begin
            mclk = ~mclk;
            if ((ph == 2 || ph == 3) && wait_n && (k_read(mk) || mk == 3'd5)) mrdata = ad_in;
            case (ph)
                1:       nx = 2;
                2, 3:    nx = wait_n ? 4 : 3;
                4:       nx = (mk == 3'd0) ? 5 : 0;
                default: nx = 0;
            endcase
            if ((ph == 0 || m_done()) && req && req_kind <= 3'd6) begin
                nx = 1; mk = req_kind; ma = req_addr; mw = req_wdata;
                mwaits = req_waits; mnoise = req_noise; mwcnt = 0;
            end
            if (nx == 3) mwcnt++;
            ph = nx;
        end
    end

    // wait and bus-data driver
    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        ad_in = lfsr;
        if (ph == 2 || ph == 3) wait_n = (mwcnt < mwaits) ? 1'b0 : 1'b1;
        else                    wait_n = mnoise ? 1'b0 : 1'b1;   // R8: noise outside T2/TW
    end

    // per-cycle comparison, 1.5 ns after the negedge drives
    always @(posedge clk) begin
        logic       e_oe;
        logic [7:0] e_ad, e_hi;
        #4;
        e_oe = 1'b0; e_ad = '0;
        if (ph == 1) begin e_oe = 1'b1; e_ad = ma[7:0]; end
        else if (mk == 3'd0 && (ph == 4 || ph == 5)) begin e_oe = 1'b1; e_ad = rfsh_addr; end
        else if (k_write(mk) && (ph == 2 || ph == 3 || ph == 4)) begin e_oe = 1'b1; e_ad = mw; end
        if (ph == 0) e_hi = '0;
        else if (mk == 3'd0 && (ph == 4 || ph == 5)) e_hi = ivec;
        else if (mk == 3'd3 || mk == 3'd4) e_hi = ma[7:0];
        else e_hi = ma[15:8];
        chk("R3", "ale", ale, (ph == 1) || (ph == 4 && mk == 3'd0));
        chk("R4", "rfsh_n", rfsh_n, !(mk == 3'd0 && (ph == 4 || ph == 5)));
        chk("R5", "ad_oe", ad_oe, e_oe);
        chk("R5", "ad_out", ad_out, e_ad);
        chk("R5", "a_hi", a_hi, e_hi);
        chk("R6", "io_m", io_m, ph != 0 && (mk >= 3'd3 && mk <= 3'd6));
        chk("R7", "rd_n", rd_n, !((ph == 2 || ph == 3) && k_read(mk)));
        chk("R7", "inta_n", inta_n, !((ph == 2 || ph == 3) && mk == 3'd5));
        chk("R10", "wr_n", wr_n, !(ph == 4 && k_write(mk)));
        chk("R2", "done", done, m_done());
        chk("R9", "rdata", rdata, mrdata);
        chk("R11", "clk_out", clk_out, mclk);
        if (!rst) begin
            if (ale && rfsh_n) obs_len = 1;
            else obs_len++;
            if (done) chk("R8", "cycle_len", obs_len, 3 + mwaits + ((mk == 3'd0) ? 1 : 0));
        end
    end

    task automatic issue(input logic [2:0] k, input logic [15:0] a, input logic [7:0] d,
                         input int waits, input bit noise, input bit scramble);
        @(negedge clk);
        while (!(ph == 0 || m_done())) @(negedge clk);
        req = 1'b1; req_kind = k; req_addr = a; req_wdata = d;
        req_waits = waits; req_noise = noise;
        @(negedge clk);
        req = 1'b0;
        if (scramble) begin
            req_addr = ~a; req_wdata = ~d; req_kind = 3'd4;
            #1;
            chk("R12", "t1_ad_out", ad_out, a[7:0]);
            chk("R12", "t1_a_hi", a_hi, a[15:8]);
        end
    endtask

    task automatic drain();
        @(negedge clk);
        while (ph != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; req = 1'b0; req_kind = '0; req_addr = '0; req_wdata = '0;
        rfsh_addr = 8'h11; ivec = 8'hc3;
        repeat (4) @(negedge clk);
        #1;
        chk("R1", "reset_ale", ale, 1'b0);
        chk("R1", "reset_strobes", {rd_n, wr_n, inta_n, rfsh_n}, 4'hf);
        chk("R1", "reset_bus", {ad_oe, ad_out, a_hi}, '0);
        chk("R1", "reset_misc", {io_m, done, rdata, clk_out}, '0);
        rst = 1'b0;

        issue(3'd0, 16'h1234, 8'h00, 0, 1'b0, 1'b0);   // fetch, no wait
        drain();
        issue(3'd0, 16'hab40, 8'h00, 2, 1'b1, 1'b0);   // fetch, waits, noise
        drain();
        rfsh_addr = 8'h7e; ivec = 8'h29;
        issue(3'd1, 16'h8001, 8'h00, 1, 1'b0, 1'b0);
        drain();
        issue(3'd2, 16'h4455, 8'h9c, 0, 1'b0, 1'b0);
        drain();
        issue(3'd2, 16'h0f0f, 8'h3a, 3, 1'b1, 1'b0);
        drain();
        issue(3'd3, 16'h00a7, 8'h00, 1, 1'b1, 1'b0);
        drain();
        issue(3'd4, 16'h0062, 8'he1, 2, 1'b0, 1'b0);
        drain();
        issue(3'd5, 16'h0000, 8'h00, 2, 1'b1, 1'b0);   // interrupt acknowledge
        drain();
        issue(3'd6, 16'h0038, 8'h00, 2, 1'b0, 1'b0);   // post-acceptance, no strobe
        drain();

        // R2: kind code 7 ignored
        issue(3'd7, 16'h5555, 8'h55, 0, 1'b0, 1'b0);
        #1;
        chk("R2", "illegal_kind_ale", ale, 1'b0);
        chk("R2", "illegal_kind_oe", ad_oe, 1'b0);
        drain();

        // back-to-back chain
        issue(3'd1, 16'hc0de, 8'h00, 0, 1'b0, 1'b0);
        issue(3'd2, 16'hc0df, 8'h77, 1, 1'b0, 1'b0);
        issue(3'd0, 16'h2000, 8'h00, 1, 1'b1, 1'b0);
        issue(3'd0, 16'h2001, 8'h00, 0, 1'b0, 1'b0);
        issue(3'd4, 16'h00f3, 8'h18, 0, 1'b1, 1'b0);
        drain();

        // R12: inputs scrambled mid-cycle
        issue(3'd2, 16'h6a95, 8'hb4, 1, 1'b0, 1'b1);
        drain();
        issue(3'd1, 16'h3c81, 8'h00, 2, 1'b1, 1'b1);
        drain();

        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule